// File: doc/BRIEF.md
# Character LCD Address Counter

This block holds the display-data address counter and the view shift offset of a character LCD controller. The controller can lay out its display as one line, two lines or four lines. Decoded commands arrive as single-cycle strobes:

- **Home:** clears the counter and the offset.
- **Load:** writes a new address.
- **Move:** either steps the cursor or shifts the whole view, selected by a view bit and a direction bit.
- **Access:** reports that one RAM data transfer has finished, so the counter steps in the direction of the entry mode.

Each line mode has its own address window. In one-line mode the window is one line of 80 positions. In two-line mode there are two lines of 40 positions starting at 00h and 40h. In four-line mode there are four lines of 20 positions starting at 00h, 20h, 40h and 60h. When the counter steps past the last column of a line, it lands on the first column of the next line. Stepping past the end of the last line wraps to 00h, and stepping back from 00h lands on the last position of the last line.

A view shift changes only the offset. The offset counts left shifts modulo the line length of the current mode, and it applies to all lines at once.

Top module: `lcd_addr_ctr`

## Requirements
- R1: After reset, `addr` and `view_ofs` are both 00h.
- R2: `four_line`=1 selects the four-line layout whatever `two_line` is. Otherwise `two_line`=1 selects two lines and `two_line`=0 selects one line.
- R3: In one-line mode the legal range is 00h..4Fh. Stepping up from 4Fh gives 00h, and stepping down from 00h gives 4Fh. Every other step is ±1.
- R4: In two-line mode the lines are 00h..27h and 40h..67h. The up-steps at the ends are 27h→40h and 67h→00h. The down-steps at the starts are 40h→27h and 00h→67h.
- R5: In four-line mode the lines are 00h..13h, 20h..33h, 40h..53h and 60h..73h. The up-steps at the ends are 13h→20h, 33h→40h, 53h→60h and 73h→00h. Down-steps at line starts run the reverse way, and 00h→73h.
- R6: A move with `move_view`=0 steps the address down when `move_right`=0 and up when `move_right`=1, using the rules of R3 to R5.
- R7: A move with `move_view`=1 leaves `addr` unchanged. `move_right`=0 adds 1 to `view_ofs` and `move_right`=1 subtracts 1, both modulo the line length (80, 40 or 20). If the offset is not below the line length, a right shift loads length−1.
- R8: An access strobe steps the address up when `entry_up`=1 and down when `entry_up`=0.
- R9: A load with an address inside the current window loads that address. A load with an address outside the window loads 00h. Any step from an address outside the window also gives 00h.
- R10: A home strobe sets both `addr` and `view_ofs` to 00h and overrides every other command in that cycle.
- R11: For the address, a load takes priority over a cursor move, and a cursor move takes priority over an access. A view shift acts on the offset in the same cycle as any of these address commands.
- R12: Every command takes effect on the first rising clock edge at which it is sampled. With no command present, both outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| four_line | input | 1 | Four-line layout select |
| two_line | input | 1 | Two-line select when four_line is low |
| home_cmd | input | 1 | Clear address and offset |
| load_cmd | input | 1 | Load `load_addr` |
| load_addr | input | 7 | Address to load |
| move_cmd | input | 1 | Cursor or view move |
| move_view | input | 1 | 1: shift the view, 0: move the cursor |
| move_right | input | 1 | Move direction, 1 = right |
| access_cmd | input | 1 | RAM data transfer done |
| entry_up | input | 1 | Entry-mode direction, 1 = increment |
| addr | output | 7 | Address counter |
| view_ofs | output | 7 | View shift offset (count of left shifts) |

## Verification
A view shift and an address change can fall in the same cycle. The address change may come from an access, a cursor move or a load, and both the counter and the offset must update together. A cursor move can also collide with an access or a load, and only the higher-priority one may change the address. The bench provokes these cases with directed cycles that raise the strobes together, and with random cycles that assert every strobe independently. After each edge it compares both outputs with a bench model that applies the priority order of R10 and R11.

// File: rtl/lcd_ac_pkg.sv
package lcd_ac_pkg;
  typedef enum logic [1:0] {
    LM_ONE  = 2'd0,
    LM_TWO  = 2'd1,
    LM_FOUR = 2'd2
  } line_mode_e;
endpackage

// File: rtl/lcd_ac_geom.sv
module lcd_ac_geom
  import lcd_ac_pkg::*;
#(
  parameter int AW   = 7,
  parameter int LEN1 = 80,
  parameter int LEN2 = 40,
  parameter int LEN4 = 20
) (
  input  logic          four_line,
  input  logic          two_line,
  output line_mode_e    lmode,
  output logic [AW:0]   line_len,
  output logic [1:0]    last_line
);
  always_comb begin
    if (four_line) begin
      lmode     = LM_FOUR;
      line_len  = (AW+1)'(LEN4);
      last_line = 2'd3;
    end else if (two_line) begin
      lmode     = LM_TWO;
      line_len  = (AW+1)'(LEN2);
      last_line = 2'd1;
    end else begin
      lmode     = LM_ONE;
      line_len  = (AW+1)'(LEN1);
      last_line = 2'd0;
    end
  end
endmodule

// File: rtl/lcd_ac_step.sv
module lcd_ac_step
  import lcd_ac_pkg::*;
#(
  parameter int AW = 7
) (
  input  line_mode_e    lmode,
  input  logic [AW:0]   line_len,
  input  logic [1:0]    last_line,
  input  logic [AW-1:0] cur,
  input  logic          dir_up,
  output logic          legal,
  output logic [AW-1:0] nxt
);
  logic [1:0]    line;
  logic [AW-1:0] col;
  logic [AW-1:0] len_m1;

  function automatic logic [AW-1:0] start_of(input line_mode_e m, input logic [1:0] ln);
    case (m)
      LM_FOUR: return {ln, {(AW-2){1'b0}}};
      LM_TWO:  return {ln[0], {(AW-1){1'b0}}};
      default: return '0;
    endcase
  endfunction

  assign len_m1 = line_len[AW-1:0] - {{(AW-1){1'b0}}, 1'b1};

  always_comb begin
    case (lmode)
      LM_FOUR: begin
        line = cur[AW-1 -: 2];
        col  = {2'b00, cur[AW-3:0]};
      end
      LM_TWO: begin
        line = {1'b0, cur[AW-1]};
        col  = {1'b0, cur[AW-2:0]};
      end
      default: begin
        line = 2'd0;
        col  = cur;
      end
    endcase
    legal = (line <= last_line) && ({1'b0, col} < line_len);

    if (!legal) begin
      nxt = '0;
    end else if (dir_up) begin
      if (col == len_m1) nxt = (line == last_line) ? '0 : start_of(lmode, line + 2'd1);
      else               nxt = cur + {{(AW-1){1'b0}}, 1'b1};
    end else begin
      if (col == '0) nxt = (line == 2'd0) ? start_of(lmode, last_line) + len_m1
                                          : start_of(lmode, line - 2'd1) + len_m1;
      else           nxt = cur - {{(AW-1){1'b0}}, 1'b1};
    end
  end
endmodule

// File: rtl/lcd_ac_ofs.sv
module lcd_ac_ofs #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          shift_en,
  input  logic          shift_right,
  input  logic [AW:0]   line_len,
  output logic [AW-1:0] ofs
);
  logic [AW-1:0] ofs_q, ofs_d;
  logic          ofs_en;
  logic [AW-1:0] len_m1;

  assign len_m1 = line_len[AW-1:0] - {{(AW-1){1'b0}}, 1'b1};
  assign ofs_en = clr | shift_en;

  always_comb begin
    if (clr)
      ofs_d = '0;
    else if (shift_right)
      ofs_d = (ofs_q == '0 || {1'b0, ofs_q} >= line_len) ? len_m1
                                                         : ofs_q - {{(AW-1){1'b0}}, 1'b1};
    else
      ofs_d = (ofs_q >= len_m1) ? '0 : ofs_q + {{(AW-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ofs_q <= '0;
    else if (ofs_en) ofs_q <= ofs_d;
  end

  assign ofs = ofs_q;
endmodule

// File: rtl/lcd_addr_ctr.sv
module lcd_addr_ctr
  import lcd_ac_pkg::*;
#(
  parameter int AW   = 7,
  parameter int LEN1 = 80,
  parameter int LEN2 = 40,
  parameter int LEN4 = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          four_line,
  input  logic          two_line,
  input  logic          home_cmd,
  input  logic          load_cmd,
  input  logic [AW-1:0] load_addr,
  input  logic          move_cmd,
  input  logic          move_view,
  input  logic          move_right,
  input  logic          access_cmd,
  input  logic          entry_up,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] view_ofs
);
  logic [1:0]    rst_sync;
  logic          rst_int_n;
  line_mode_e    lmode;
  logic [AW:0]   line_len;
  logic [1:0]    last_line;
  logic [AW-1:0] addr_q, addr_d, step_nxt, load_unused;
  logic          addr_en, cursor_mv, step_up, load_ok, step_legal_unused;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  lcd_ac_geom #(.AW(AW), .LEN1(LEN1), .LEN2(LEN2), .LEN4(LEN4)) u_geom (
    .four_line(four_line), .two_line(two_line),
    .lmode(lmode), .line_len(line_len), .last_line(last_line)
  );

  assign cursor_mv = move_cmd & ~move_view;
  assign step_up   = cursor_mv ? move_right : entry_up;

  lcd_ac_step #(.AW(AW)) u_step (
    .lmode(lmode), .line_len(line_len), .last_line(last_line),
    .cur(addr_q), .dir_up(step_up),
    .legal(step_legal_unused), .nxt(step_nxt)
  );

  lcd_ac_step #(.AW(AW)) u_win (
    .lmode(lmode), .line_len(line_len), .last_line(last_line),
    .cur(load_addr), .dir_up(1'b1),
    .legal(load_ok), .nxt(load_unused)
  );

  assign addr_en = home_cmd | load_cmd | cursor_mv | access_cmd;

  always_comb begin
    if (home_cmd)      addr_d = '0;
    else if (load_cmd) addr_d = load_ok ? load_addr : '0;
    else               addr_d = step_nxt;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  lcd_ac_ofs #(.AW(AW)) u_ofs (
    .clk(clk), .rst_n(rst_int_n), .clr(home_cmd),
    .shift_en(move_cmd & move_view), .shift_right(move_right),
    .line_len(line_len), .ofs(view_ofs)
  );

  assign addr = addr_q;
endmodule

// File: rtl/lcd_ac_chk.sv
module lcd_ac_chk #(
  parameter int AW   = 7,
  parameter int LEN1 = 80,
  parameter int LEN2 = 40,
  parameter int LEN4 = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          four_line,
  input logic          two_line,
  input logic          home_cmd,
  input logic          load_cmd,
  input logic [AW-1:0] load_addr,
  input logic          move_cmd,
  input logic          move_view,
  input logic          access_cmd,
  input logic          entry_up,
  input logic [AW-1:0] addr,
  input logic [AW-1:0] view_ofs
);
  localparam logic [AW-1:0] L1 = AW'(LEN1);
  localparam logic [AW-1:0] L2 = AW'(LEN2);
  localparam logic [AW-1:0] L4 = AW'(LEN4);

  logic load_in_win, quiet, one_mode;
  assign load_in_win = four_line ? ({2'b00, load_addr[AW-3:0]} < L4) :
                       two_line  ? ({1'b0,  load_addr[AW-2:0]} < L2) : (load_addr < L1);
  assign quiet    = !home_cmd && !load_cmd && !move_cmd && !access_cmd;
  assign one_mode = !four_line && !two_line;

  a_r10_home_clears: assert property (@(posedge clk) disable iff (!rst_n)
    home_cmd |=> (addr == '0 && view_ofs == '0));

  a_r7_view_keeps_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (!home_cmd && !load_cmd && !access_cmd && move_cmd && move_view) |=> $stable(addr));

  a_r7_ofs_below_len: assert property (@(posedge clk) disable iff (!rst_n)
    view_ofs < L1);

  a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |=> ($stable(addr) && $stable(view_ofs)));

  a_r9_bad_load_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!home_cmd && load_cmd && !load_in_win) |=> (addr == '0));

  a_r8_access_up: assert property (@(posedge clk) disable iff (!rst_n)
    (one_mode && !home_cmd && !load_cmd && !move_cmd && access_cmd && entry_up &&
     addr < L1 - 1'b1) |=> (addr == $past(addr) + 1'b1));

  a_r3_wrap_top: assert property (@(posedge clk) disable iff (!rst_n)
    (one_mode && !home_cmd && !load_cmd && !move_cmd && access_cmd && entry_up &&
     addr == L1 - 1'b1) |=> (addr == '0));
endmodule

bind lcd_addr_ctr lcd_ac_chk #(.AW(AW), .LEN1(LEN1), .LEN2(LEN2), .LEN4(LEN4)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .four_line(four_line), .two_line(two_line),
  .home_cmd(home_cmd), .load_cmd(load_cmd), .load_addr(load_addr),
  .move_cmd(move_cmd), .move_view(move_view), .access_cmd(access_cmd),
  .entry_up(entry_up), .addr(addr), .view_ofs(view_ofs)
);

// File: tb/sim_lcd_addr_ctr.sv
module sim_lcd_addr_ctr;
  logic clk = 1'b0;
  logic rst_n;
  logic four_line, two_line, home_cmd, load_cmd, move_cmd, move_view, move_right;
  logic access_cmd, entry_up;
  logic [6:0] load_addr, addr, view_ofs;

  int n_chk  = 0;
  int n_fail = 0;
  int e_addr = 0;
  int e_ofs  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  lcd_addr_ctr u0 (
    .clk(clk), .rst_n(rst_n), .four_line(four_line), .two_line(two_line),
    .home_cmd(home_cmd), .load_cmd(load_cmd), .load_addr(load_addr),
    .move_cmd(move_cmd), .move_view(move_view), .move_right(move_right),
    .access_cmd(access_cmd), .entry_up(entry_up), .addr(addr), .view_ofs(view_ofs)
  );

  function automatic int m_lines(input bit f, input bit t);
    return f ? 4 : (t ? 2 : 1);
  endfunction
  function automatic int m_len(input bit f, input bit t);
    return f ? 20 : (t ? 40 : 80);
  endfunction

  function automatic bit m_legal(input int a, input bit f, input bit t);
    int stride = 128 / m_lines(f, t);
    return (a / stride) < m_lines(f, t) && (a % stride) < m_len(f, t);
  endfunction

  function automatic int m_step(input int a, input bit up, input bit f, input bit t);
    int n = m_lines(f, t);
    int len = m_len(f, t);
    int stride = 128 / n;
    int k = a / stride;
    int c = a % stride;
    if (!m_legal(a, f, t)) return 0;
    if (up)  return (c == len - 1) ? ((k == n - 1) ? 0 : (k + 1) * stride) : a + 1;
    return (c == 0) ? (((k == 0) ? n - 1 : k - 1) * stride + len - 1) : a - 1;
  endfunction

  function automatic int m_ofs(input int o, input bit right, input int len);
    if (right) return (o == 0 || o >= len) ? len - 1 : o - 1;
    return (o + 1 >= len) ? 0 : o + 1;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    home_cmd = 0; load_cmd = 0; load_addr = '0; move_cmd = 0;
    move_view = 0; move_right = 0; access_cmd = 0; entry_up = 0;
  endtask

  // drive one command cycle, update model, compare after the edge
  task automatic cmd(input string tag, input bit h, input bit l, input int la,
                     input bit mv, input bit vw, input bit rt, input bit ac, input bit up);
    @(negedge clk);
    home_cmd = h; load_cmd = l; load_addr = 7'(la); move_cmd = mv;
    move_view = vw; move_right = rt; access_cmd = ac; entry_up = up;
    if (h) begin
      e_addr = 0; e_ofs = 0;
    end else begin
      if (l)             e_addr = m_legal(la, four_line, two_line) ? la : 0;
      else if (mv && !vw) e_addr = m_step(e_addr, rt, four_line, two_line);
      else if (ac)       e_addr = m_step(e_addr, up, four_line, two_line);
      if (mv && vw)      e_ofs = m_ofs(e_ofs, rt, m_len(four_line, two_line));
    end
    @(posedge clk); #1;
    check({tag, " addr"}, int'(addr), e_addr);
    check({tag, " ofs"}, int'(view_ofs), e_ofs);
    idle_inputs();
  endtask

  task automatic set_mode(input bit f, input bit t);
    @(negedge clk);
    four_line = f; two_line = t;
  endtask

  initial begin
    #600000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; four_line = 0; two_line = 0;
    idle_inputs();
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset addr", int'(addr), 0);
    check("R1 reset ofs", int'(view_ofs), 0);
    @(negedge clk); rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1 after release addr", int'(addr), 0);

    // one-line
    set_mode(0, 0);
    cmd("R9 load 4F", 0, 1, 'h4F, 0, 0, 0, 0, 0);
    cmd("R3 up wrap", 0, 0, 0, 0, 0, 0, 1, 1);
    cmd("R3 down wrap", 0, 0, 0, 0, 0, 0, 1, 0);
    cmd("R8 down step", 0, 0, 0, 0, 0, 0, 1, 0);
    // R12: no change before the edge
    @(negedge clk);
    access_cmd = 1; entry_up = 1;
    #1 check("R12 before edge", int'(addr), e_addr);
    e_addr = m_step(e_addr, 1, 0, 0);
    @(posedge clk); #1;
    check("R12 after edge", int'(addr), e_addr);
    idle_inputs();
    cmd("R12 idle", 0, 0, 0, 0, 0, 0, 0, 0);

    // two-line
    set_mode(0, 1);
    cmd("R4 load 27", 0, 1, 'h27, 0, 0, 0, 0, 0);
    cmd("R6 R4 right to 40", 0, 0, 0, 1, 0, 1, 0, 0);
    cmd("R6 R4 left to 27", 0, 0, 0, 1, 0, 0, 0, 0);
    cmd("R4 load 67", 0, 1, 'h67, 0, 0, 0, 0, 0);
    cmd("R4 up wrap", 0, 0, 0, 0, 0, 0, 1, 1);
    cmd("R4 down wrap", 0, 0, 0, 0, 0, 0, 1, 0);
    cmd("R9 illegal 30", 0, 1, 'h30, 0, 0, 0, 0, 0);

    // four-line, two_line also high
    set_mode(1, 1);
    cmd("R2 load 13", 0, 1, 'h13, 0, 0, 0, 0, 0);
    cmd("R2 R5 up to 20", 0, 0, 0, 0, 0, 0, 1, 1);
    cmd("R5 down to 13", 0, 0, 0, 0, 0, 0, 1, 0);
    cmd("R5 load 53", 0, 1, 'h53, 0, 0, 0, 0, 0);
    cmd("R5 up to 60", 0, 0, 0, 0, 0, 0, 1, 1);
    cmd("R5 load 73", 0, 1, 'h73, 0, 0, 0, 0, 0);
    cmd("R5 up wrap", 0, 0, 0, 0, 0, 0, 1, 1);
    cmd("R5 down wrap", 0, 0, 0, 0, 0, 0, 1, 0);
    cmd("R9 illegal 15", 0, 1, 'h15, 0, 0, 0, 0, 0);
    cmd("R7 view left", 0, 0, 0, 1, 1, 0, 0, 0);
    cmd("R7 view right", 0, 0, 0, 1, 1, 1, 0, 0);
    cmd("R7 view right wrap", 0, 0, 0, 1, 1, 1, 0, 0);
    cmd("R11 view plus access", 0, 0, 0, 1, 1, 0, 1, 1);
    cmd("R11 load beats cursor", 0, 1, 'h42, 1, 0, 1, 0, 0);
    cmd("R11 cursor beats access", 0, 0, 0, 1, 0, 0, 1, 1);
    cmd("R10 home beats all", 1, 1, 'h33, 1, 1, 1, 1, 1);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      if (i % 250 == 0) set_mode(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      cmd("R11 random",
          ($urandom_range(0, 49) == 0),
          ($urandom_range(0, 7) == 0),
          int'($urandom_range(0, 127)),
          ($urandom_range(0, 2) == 0),
          1'($urandom_range(0, 1)),
          1'($urandom_range(0, 1)),
          ($urandom_range(0, 1) == 0),
          1'($urandom_range(0, 1)));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule